// File: doc/BRIEF.md
# Framed Pausable Serial Register Writer

This block is the receive side of a serial write port. An external master shifts fixed 24-bit words in on a serial clock and data line. The master frames the transfer with an active-low frame strobe and picks a destination with a select line. The block takes all four inputs into a fast system clock through two-flop synchronizers and treats a rising edge of the synchronized serial clock as the bit-sampling event. The system clock must run at least four times faster than the serial clock.

The master may raise the frame strobe while the serial clock is low, part-way through a word. The block then holds its bit count and partial word until the strobe falls again, so one word can arrive in several bursts. When the last bit of a word arrives, the block pulses a one-cycle write strobe together with the destination index, and the word lands in either the control register or the calibration register. A separate ready flag, owned by other logic, passes through the block, and write traffic cannot change it.

The receiver is a five-state machine:

- S_IDLE: waiting for the first bit of a word.
- S_SHIFT: the frame is open and the word is partly received.
- S_PAUSE: the frame is suspended mid-word.
- S_COMMIT: the one-cycle write pulse.
- S_FAULT: the select line moved mid-word; bits are dropped until the frame closes.

Its transitions are:

- IDLE to SHIFT on the first framed bit.
- SHIFT to PAUSE when the frame strobe goes high.
- PAUSE to SHIFT when the frame strobe goes low again.
- SHIFT to COMMIT on the 24th bit.
- COMMIT to IDLE unconditionally.
- SHIFT or PAUSE to FAULT when the select line changes.
- FAULT to IDLE once the frame strobe is high.

Top module: `ser_wr_port`

## Requirements
- R1: Only a complete 24-bit word is ever written. A partial word leaves both destination registers unchanged, and no write strobe occurs.
- R2: Bits are taken most-significant first, one per rising serial-clock edge, so the register receives the word exactly as sent.
- R3: If the frame strobe rises mid-word, the received bits and the bit count are held. After the strobe falls again, the next rising serial-clock edge loads the next bit of the same word.
- R4: On the 24th bit, wr_stb is high for exactly one system-clock cycle with wr_dst giving the destination. The selected register updates on the following clock edge, and the next bit starts a new word.
- R5: dst_sel low (0) at the first bit selects the control register (wr_dst=0, ctrl_q). dst_sel high (1) selects the calibration register (wr_dst=1, cal_q). The other register is unchanged.
- R6: A change of dst_sel after the first bit and before the word completes sets err_flag, which stays set until reset. That word is discarded, and bits are ignored until the frame strobe goes high.
- R7: Rising serial-clock edges while the frame strobe is high load no bit, whether the block is idle or paused.
- R8: rdy_out always equals rdy_in, regardless of write activity.
- R9: Synchronous reset clears ctrl_q, cal_q, err_flag, the bit count and the partial word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock from the master, idles low |
| ser_dat | input | 1 | Serial data, MSB first |
| frm_n | input | 1 | Active-low frame strobe |
| dst_sel | input | 1 | Destination select: 0 control, 1 calibration |
| rdy_in | input | 1 | Ready flag from other logic |
| rdy_out | output | 1 | Ready flag passed through unchanged |
| ctrl_q | output | 24 | Control register contents |
| cal_q | output | 24 | Calibration register contents |
| wr_stb | output | 1 | One-cycle write pulse |
| wr_dst | output | 1 | Destination index during wr_stb |
| err_flag | output | 1 | Sticky select-change error |

## Verification
A rising edge on ser_clk passes two synchronizer flops and one edge-detect flop, so the state machine acts on it at the third system-clock edge. For the last bit, wr_stb is therefore high during the fourth cycle after the input edge, and the destination register changes one edge later. The bench keeps ser_clk high for four system cycles and then low for four more before it checks any register or the strobe count, so every result is settled well before it is sampled. Strobes are counted on falling system-clock edges, and the ready pass-through is compared one time unit after each change of rdy_in.

// File: rtl/ser_wr_pkg.sv
package ser_wr_pkg;
    localparam int WORD_BITS = 24;
    localparam int N_DEST    = 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SHIFT,
        S_PAUSE,
        S_COMMIT,
        S_FAULT
    } wr_state_e;
endpackage

// File: rtl/ser_wr_sync.sv
module ser_wr_sync #(
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/ser_wr_fsm.sv
module ser_wr_fsm
    import ser_wr_pkg::*;
#(
    parameter int WORD_W = WORD_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_s,
    input  logic              sdat_s,
    input  logic              frm_n_s,
    input  logic              sel_s,
    output logic [WORD_W-1:0] word_o,
    output logic              dst_o,
    output logic              stb_o,
    output logic              err_o
);
    localparam int CW = $clog2(WORD_W + 1);
    localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

    wr_state_e         state, nxt;
    logic [CW-1:0]     cnt;
    logic [WORD_W-1:0] shreg;
    logic              sel_lat;
    logic              sclk_prev;
    logic              err;
    logic              rise;
    logic              take;
    logic              moved;

    assign rise  = sclk_s & ~sclk_prev;
    assign take  = rise & ~frm_n_s;
    assign moved = (sel_s != sel_lat);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (take) nxt = S_SHIFT;
            S_SHIFT: begin
                if (moved)        nxt = S_FAULT;
                else if (frm_n_s) nxt = S_PAUSE;
                else if (rise)    nxt = (cnt == LAST) ? S_COMMIT : S_SHIFT;
            end
            S_PAUSE: begin
                if (moved)         nxt = S_FAULT;
                else if (!frm_n_s) nxt = S_SHIFT;
            end
            S_COMMIT: nxt = S_IDLE;
            S_FAULT:  if (frm_n_s) nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            sel_lat   <= 1'b0;
            sclk_prev <= 1'b0;
            err       <= 1'b0;
        end else begin
            state     <= nxt;
            sclk_prev <= sclk_s;
            unique case (state)
                S_IDLE: if (take) begin
                    shreg   <= {shreg[WORD_W-2:0], sdat_s};
                    cnt     <= CW'(1);
                    sel_lat <= sel_s;
                end
                S_SHIFT: begin
                    if (moved) begin
                        err <= 1'b1;
                    end else if (take) begin
                        shreg <= {shreg[WORD_W-2:0], sdat_s};
                        cnt   <= (cnt == LAST) ? '0 : cnt + CW'(1);
                    end
                end
                S_PAUSE:  if (moved) err <= 1'b1;
                S_COMMIT: cnt <= '0;
                S_FAULT:  cnt <= '0;
                default:  cnt <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        stb_o  = (state == S_COMMIT);
        dst_o  = sel_lat;
        word_o = shreg;
        err_o  = err;
    end

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        stb_o |=> !stb_o);                                            // R4
    AST_FULL_WORD: assert property (@(posedge clk) disable iff (rst)
        stb_o |-> ($past(state) == S_SHIFT && $past(cnt) == LAST));   // R1
    AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == S_PAUSE) |=> ($stable(shreg) && $stable(cnt)));     // R3
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err |=> err);                                                 // R6
    AST_FAULT_NO_STB: assert property (@(posedge clk) disable iff (rst)
        (state == S_FAULT) |=> !stb_o);                               // R6
endmodule

// File: rtl/ser_wr_regs.sv
module ser_wr_regs
    import ser_wr_pkg::*;
#(
    parameter int WORD_W = WORD_BITS,
    parameter int NDST   = N_DEST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic              dst,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] q [NDST]
);
    for (genvar g = 0; g < NDST; g++) begin : g_dest
        always_ff @(posedge clk) begin
            if (rst)
                q[g] <= '0;
            else if (stb && (32'(dst) == g))
                q[g] <= word;
        end

        AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
            !stb |=> $stable(q[g]));                                  // R1
    end
endmodule

// File: rtl/ser_wr_port.sv
module ser_wr_port
    import ser_wr_pkg::*;
#(
    parameter int WORD_W = WORD_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              frm_n,
    input  logic              dst_sel,
    input  logic              rdy_in,
    output logic              rdy_out,
    output logic [WORD_W-1:0] ctrl_q,
    output logic [WORD_W-1:0] cal_q,
    output logic              wr_stb,
    output logic              wr_dst,
    output logic              err_flag
);
    logic [3:0]        sync_q;
    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] bank [N_DEST];

    // bit order: {sel, frame_n, data, sclk}; frame idles high
    ser_wr_sync #(.W(4), .RST_VAL(4'b0100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({dst_sel, frm_n, ser_dat, ser_clk}),
        .q   (sync_q)
    );

    ser_wr_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .sclk_s  (sync_q[0]),
        .sdat_s  (sync_q[1]),
        .frm_n_s (sync_q[2]),
        .sel_s   (sync_q[3]),
        .word_o  (word),
        .dst_o   (wr_dst),
        .stb_o   (wr_stb),
        .err_o   (err_flag)
    );

    ser_wr_regs #(.WORD_W(WORD_W), .NDST(N_DEST)) u_regs (
        .clk  (clk),
        .rst  (rst),
        .stb  (wr_stb),
        .dst  (wr_dst),
        .word (word),
        .q    (bank)
    );

    assign ctrl_q  = bank[0];
    assign cal_q   = bank[1];
    assign rdy_out = rdy_in;   // ready flag is never touched by writes
endmodule

// File: tb/ser_wr_port_tb.sv
`timescale 1ns/1ps
module ser_wr_port_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        frm_n = 1'b1;
    logic        dst_sel = 1'b0;
    logic        rdy_in = 1'b0;
    logic        rdy_out;
    logic [23:0] ctrl_q, cal_q;
    logic        wr_stb, wr_dst, err_flag;

    int checks = 0, fails = 0;
    int stb_cnt = 0;
    logic last_dst = 1'b0;
    int rdy_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;  // 250 MHz

    ser_wr_port u_dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .frm_n(frm_n), .dst_sel(dst_sel), .rdy_in(rdy_in), .rdy_out(rdy_out),
        .ctrl_q(ctrl_q), .cal_q(cal_q), .wr_stb(wr_stb), .wr_dst(wr_dst),
        .err_flag(err_flag)
    );

    always @(negedge clk) if (wr_stb) begin
        stb_cnt++;
        last_dst = wr_dst;
    end

    initial forever begin
        repeat (7) @(negedge clk);
        rdy_in = ~rdy_in;
        #1;
        if (rdy_out !== rdy_in) rdy_bad++;
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bits(input logic [23:0] w, input int hi, input int lo);
        for (int i = hi; i >= lo; i--) begin
            ser_dat = w[i];
            repeat (4) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
        end
    endtask

    task automatic pause_gap();
        repeat (2) @(negedge clk);
        frm_n = 1'b1;
        // serial-clock pulses with the frame high must be ignored (R7)
        for (int k = 0; k < 2; k++) begin
            ser_dat = ~ser_dat;
            repeat (4) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (6) @(negedge clk);
        frm_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic write_word(input logic sel, input logic [23:0] w, input int bursts);
        dst_sel = sel;
        frm_n = 1'b0;
        repeat (4) @(negedge clk);
        if (bursts == 1) bits(w, 23, 0);
        else if (bursts == 2) begin
            bits(w, 23, 12); pause_gap(); bits(w, 11, 0);
        end else begin
            bits(w, 23, 16); pause_gap(); bits(w, 15, 8); pause_gap(); bits(w, 7, 0);
        end
        repeat (2) @(negedge clk);
        frm_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R9 ctrl_q", 32'(ctrl_q), 0);
        chk("R9 cal_q", 32'(cal_q), 0);
        chk("R9 err_flag", 32'(err_flag), 0);
        chk("R9 wr_stb", 32'(wr_stb), 0);
    endtask

    task automatic t_single_ctrl();
        int s0 = stb_cnt;
        // idle serial-clock pulses with the frame high first (R7)
        for (int k = 0; k < 3; k++) begin
            ser_dat = 1'b1;
            repeat (4) @(negedge clk); ser_clk = 1'b1;
            repeat (4) @(negedge clk); ser_clk = 1'b0;
        end
        write_word(1'b0, 24'hA5C3_17, 1);
        chk("R2/R7 ctrl_q single burst", 32'(ctrl_q), 32'hA5C317);
        chk("R5 cal_q untouched", 32'(cal_q), 0);
        chk("R4 one strobe per word", 32'(stb_cnt - s0), 1);
        chk("R5 wr_dst control", 32'(last_dst), 0);
    endtask

    task automatic t_single_cal();
        write_word(1'b1, 24'h80_0001, 1);
        chk("R2 cal_q msb/lsb", 32'(cal_q), 32'h800001);
        chk("R5 wr_dst calibration", 32'(last_dst), 1);
        chk("R5 ctrl_q untouched", 32'(ctrl_q), 32'hA5C317);
    endtask

    task automatic t_two_burst();
        int s0 = stb_cnt;
        write_word(1'b0, 24'h3C_69F0, 2);
        chk("R3 two-burst ctrl_q", 32'(ctrl_q), 32'h3C69F0);
        chk("R3 two-burst single strobe", 32'(stb_cnt - s0), 1);
    endtask

    task automatic t_three_burst();
        write_word(1'b1, 24'hDE_AD5B, 3);
        chk("R3 three-burst cal_q", 32'(cal_q), 32'hDEAD5B);
        chk("R3 ctrl_q kept", 32'(ctrl_q), 32'h3C69F0);
    endtask

    task automatic t_back_to_back();
        int s0 = stb_cnt;
        frm_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            dst_sel = k[0];
            bits(24'h11_1111 * (k + 1), 23, 0);
        end
        repeat (2) @(negedge clk);
        frm_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R4 back-to-back strobes", 32'(stb_cnt - s0), 4);
        chk("R4 ctrl_q after alternation", 32'(ctrl_q), 32'h333333);
        chk("R4 cal_q after alternation", 32'(cal_q), 32'h444444);
        chk("R5 last wr_dst", 32'(last_dst), 1);
    endtask

    task automatic t_sel_change();
        int s0 = stb_cnt;
        dst_sel = 1'b0;
        frm_n = 1'b0;
        repeat (4) @(negedge clk);
        bits(24'hFFFFFF, 23, 14);
        dst_sel = 1'b1;
        bits(24'hFFFFFF, 13, 0);
        repeat (2) @(negedge clk);
        frm_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R6 err_flag set", 32'(err_flag), 1);
        chk("R6 no strobe", 32'(stb_cnt - s0), 0);
        chk("R6 ctrl_q kept", 32'(ctrl_q), 32'h333333);
        chk("R6 cal_q kept", 32'(cal_q), 32'h444444);
        write_word(1'b0, 24'h12_3456, 1);
        chk("R6 next word accepted", 32'(ctrl_q), 32'h123456);
        chk("R6 err_flag sticky", 32'(err_flag), 1);
    endtask

    task automatic t_partial();
        int s0 = stb_cnt;
        dst_sel = 1'b1;
        frm_n = 1'b0;
        repeat (4) @(negedge clk);
        bits(24'h0F0F0F, 23, 12);
        repeat (2) @(negedge clk);
        frm_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R1 partial no strobe", 32'(stb_cnt - s0), 0);
        chk("R1 partial cal_q kept", 32'(cal_q), 32'h444444);
        do_reset();
        chk("R9 ctrl_q cleared", 32'(ctrl_q), 0);
        chk("R9 err_flag cleared", 32'(err_flag), 0);
        write_word(1'b1, 24'h5A_5A5A, 1);
        chk("R9 counter restarted", 32'(cal_q), 32'h5A5A5A);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_single_ctrl();
        t_single_cal();
        t_two_burst();
        t_three_burst();
        t_back_to_back();
        t_sel_change();
        t_partial();
        chk("R8 rdy_out follows rdy_in", 32'(rdy_bad), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule